// File: doc/BRIEF.md
# Flag-Steered Context ALU

This block is a 32-bit arithmetic/logic unit for one cell of a reconfigurable datapath. Its operation is not fixed by a single configuration word. Each cycle it reads one word from a small context store. That word names the opcode, where each operand comes from, which output register receives the result, and which status flags may change. Context words are loaded one at a time through a write port, and that port stays usable while the unit runs.

The index of the active context comes from one of two places. In external mode it comes from an index input, which is normally driven by neighbouring lookup-table or state-machine logic. In flag mode it comes from the unit's own flags as they were registered on the previous clock edge. Flag mode lets a data-dependent branch take effect on the very next cycle without an outside sequencer. The unit runs on every clock cycle.

A parameter builds a single-context variant. That variant always uses context 0, so it behaves exactly like the multi-context unit with the same operation loaded into every context. Two output registers hold results, and their values can be fed back as operands.

Top module: `mcalu`

## Requirements
- R1: While reset is asserted, and on the first edge after it, every context word is zero, both output registers are zero and all four flags are zero. The all-zero context word means pass-through of `op_a` into register 0 with no flag updates.
- R2: When `cfg_we` is high, `cfg_word` is stored in context `cfg_idx` at the clock edge. The stored word governs operation from the next cycle onward, and the other contexts keep their contents. The word layout is: opcode in bits 12:9, operand-A source in 8:7, operand-B source in 6:5, destination register in bit 4, flag mask in bits 3:0.
- R3: When `sel_ext` is 1, the context used in a cycle is the one numbered by `ext_idx`.
- R4: When `sel_ext` is 0, the context used in a cycle is numbered by the registered flags from the previous edge, with carry as bit 1 and zero as bit 0.
- R5: The arithmetic opcodes are ADD (1), SUB (2) and MUL (8).
  - ADD sets carry to the unsigned carry-out and overflow to signed overflow.
  - SUB sets carry to the unsigned borrow (a < b) and overflow to signed overflow.
  - MUL keeps the low 32 bits of the product and sets overflow when the high 32 bits are nonzero.
- R6: The logic and pass opcodes are AND (3), OR (4), XOR (5) and PASS (0). Unassigned codes 9 to 15 act as PASS. All of them clear carry and overflow.
- R7: SHL (6) shifts operand A left, and SRA (7) shifts it right arithmetically. The shift amount is operand B bits 4:0. Carry is the last bit shifted out, and 0 for a zero shift. Overflow is 0.
- R8: When updated, zero is set exactly when the result is 0, and sign equals result bit 31.
- R9: Flag bit positions are zero 0, carry 1, sign 2, overflow 3. A flag whose mask bit is 0 in the active context keeps its previous value.
- R10: The operand source codes are 0 = `op_a`, 1 = `op_b`, 2 = register 0, 3 = register 1. Only the selected destination register is written; the other keeps its value.
- R11: With `MULTI_CTX` = 0, context 0 is used every cycle whatever `sel_ext`, `ext_idx` and the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Context write enable |
| cfg_idx | input | CTX_W | Context number to write |
| cfg_word | input | 13 | Context word to store |
| sel_ext | input | 1 | 1: index from `ext_idx`, 0: index from flags |
| ext_idx | input | CTX_W | Externally supplied context index |
| op_a | input | DATA_W | Operand input A |
| op_b | input | DATA_W | Operand input B |
| result_regs | output | 2*DATA_W | Output registers; register 1 in the upper half |
| flags | output | 4 | Registered flags {overflow, sign, carry, zero} |

## Verification
On every cycle, the bound assertions check the following:
- flags masked off in the active context hold their value;
- the register that is not the destination stays unchanged;
- an updated zero or sign flag agrees with the register just written;
- a context write is what the unit runs when that context is next selected externally.

Only the bench scenarios can show the arithmetic values and carry/overflow rules of each opcode, the shift edge cases, and branching through the flag-derived index. The same applies to reset clearing the contexts and to the single-context variant ignoring every index source.

// File: rtl/mcalu_pkg.sv
package mcalu_pkg;

    localparam int FLAG_N  = 4;
    localparam int NUM_DST = 2;
    localparam int CW_W    = 13;

    localparam int FZ = 0;
    localparam int FC = 1;
    localparam int FS = 2;
    localparam int FV = 3;

    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SHL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_MUL  = 4'd8
    } opcode_e;

    typedef enum logic [1:0] {
        SRC_OPA = 2'd0,
        SRC_OPB = 2'd1,
        SRC_R0  = 2'd2,
        SRC_R1  = 2'd3
    } src_e;

    typedef struct packed {
        logic [3:0]        opc;
        logic [1:0]        src_a;
        logic [1:0]        src_b;
        logic              dst;
        logic [FLAG_N-1:0] fmask;
    } ctx_word_t;

endpackage

// File: rtl/mcalu_ctx_store.sv
module mcalu_ctx_store
    import mcalu_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_idx,
    input  ctx_word_t        wr_word,
    input  logic [CTX_W-1:0] rd_idx,
    output ctx_word_t        rd_word
);

    ctx_word_t ctx_q [NUM_CTX];

    for (genvar i = 0; i < NUM_CTX; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctx_q[i] <= '0;
            end else if (wr_en && (wr_idx == CTX_W'(i))) begin
                ctx_q[i] <= wr_word;
            end
        end
    end

    always_comb begin
        rd_word = ctx_q[rd_idx];
    end

endmodule

// File: rtl/mcalu_ctx_select.sv
module mcalu_ctx_select #(
    parameter int CTX_W     = 2,
    parameter int MULTI_CTX = 1
) (
    input  logic             sel_ext,
    input  logic [CTX_W-1:0] ext_idx,
    input  logic [CTX_W-1:0] flag_idx,
    output logic [CTX_W-1:0] act_idx
);

    if (MULTI_CTX != 0) begin : g_multi
        always_comb begin
            act_idx = sel_ext ? ext_idx : flag_idx;
        end
    end else begin : g_single
        always_comb begin
            act_idx = '0;
        end
    end

endmodule

// File: rtl/mcalu_core.sv
module mcalu_core
    import mcalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [3:0]        opc,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic [FLAG_N-1:0] flg
);

    localparam int SHAMT_W = $clog2(DATA_W);

    logic [DATA_W:0]          sum_w;
    logic [DATA_W:0]          dif_w;
    logic [2*DATA_W-1:0]      shl_w;
    logic signed [DATA_W:0]   sra_w;
    logic [2*DATA_W-1:0]      prod_w;
    logic [SHAMT_W-1:0]       shamt;
    logic                     c_out;
    logic                     v_out;

    always_comb begin
        shamt  = b[SHAMT_W-1:0];
        sum_w  = {1'b0, a} + {1'b0, b};
        dif_w  = {1'b0, a} - {1'b0, b};
        shl_w  = {{DATA_W{1'b0}}, a} << shamt;
        sra_w  = $signed({a, 1'b0}) >>> shamt;
        prod_w = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        res    = a;
        c_out  = 1'b0;
        v_out  = 1'b0;
        unique case (opc)
            OP_ADD: begin
                res   = sum_w[DATA_W-1:0];
                c_out = sum_w[DATA_W];
                v_out = (a[DATA_W-1] == b[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
            end
            OP_SUB: begin
                res   = dif_w[DATA_W-1:0];
                c_out = dif_w[DATA_W];
                v_out = (a[DATA_W-1] != b[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_SHL: begin
                res   = shl_w[DATA_W-1:0];
                c_out = shl_w[DATA_W];
            end
            OP_SRA: begin
                res   = sra_w[DATA_W:1];
                c_out = sra_w[0];
            end
            OP_MUL: begin
                res   = prod_w[DATA_W-1:0];
                v_out = |prod_w[2*DATA_W-1:DATA_W];
            end
            default: res = a;
        endcase
        flg     = '0;
        flg[FZ] = (res == '0);
        flg[FC] = c_out;
        flg[FS] = res[DATA_W-1];
        flg[FV] = v_out;
    end

endmodule

// File: rtl/mcalu.sv
module mcalu
    import mcalu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_CTX   = 4,
    parameter int MULTI_CTX = 1,
    localparam int CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CTX_W-1:0]          cfg_idx,
    input  logic [CW_W-1:0]           cfg_word,
    input  logic                      sel_ext,
    input  logic [CTX_W-1:0]          ext_idx,
    input  logic [DATA_W-1:0]         op_a,
    input  logic [DATA_W-1:0]         op_b,
    output logic [NUM_DST*DATA_W-1:0] result_regs,
    output logic [FLAG_N-1:0]         flags
);

    ctx_word_t         act_ctx;
    logic [CTX_W-1:0]  act_idx;
    logic [DATA_W-1:0] regs_q [NUM_DST];
    logic [FLAG_N-1:0] flags_q;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_res;
    logic [FLAG_N-1:0] alu_flg;

    mcalu_ctx_store #(
        .NUM_CTX (NUM_CTX),
        .CTX_W   (CTX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_word (ctx_word_t'(cfg_word)),
        .rd_idx  (act_idx),
        .rd_word (act_ctx)
    );

    mcalu_ctx_select #(
        .CTX_W     (CTX_W),
        .MULTI_CTX (MULTI_CTX)
    ) u_select (
        .sel_ext  (sel_ext),
        .ext_idx  (ext_idx),
        .flag_idx (flags_q[CTX_W-1:0]),
        .act_idx  (act_idx)
    );

    function automatic logic [DATA_W-1:0] pick_src(
        input logic [1:0]        sel,
        input logic [DATA_W-1:0] pa,
        input logic [DATA_W-1:0] pb,
        input logic [DATA_W-1:0] r0,
        input logic [DATA_W-1:0] r1
    );
        logic [DATA_W-1:0] v;
        unique case (sel)
            SRC_OPA: v = pa;
            SRC_OPB: v = pb;
            SRC_R0:  v = r0;
            default: v = r1;
        endcase
        return v;
    endfunction

    always_comb begin
        opnd_a = pick_src(act_ctx.src_a, op_a, op_b, regs_q[0], regs_q[1]);
        opnd_b = pick_src(act_ctx.src_b, op_a, op_b, regs_q[0], regs_q[1]);
    end

    mcalu_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .opc (act_ctx.opc),
        .a   (opnd_a),
        .b   (opnd_b),
        .res (alu_res),
        .flg (alu_flg)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DST; i++) begin
                regs_q[i] <= '0;
            end
            flags_q <= '0;
        end else begin
            regs_q[act_ctx.dst] <= alu_res;
            flags_q <= (alu_flg & act_ctx.fmask) | (flags_q & ~act_ctx.fmask);
        end
    end

    for (genvar g = 0; g < NUM_DST; g++) begin : g_out
        assign result_regs[g*DATA_W +: DATA_W] = regs_q[g];
    end

    assign flags = flags_q;

endmodule

// File: rtl/mcalu_chk.sv
module mcalu_chk
    import mcalu_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CTX_W     = 2,
    parameter int MULTI_CTX = 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [CTX_W-1:0]          cfg_idx,
    input logic [CW_W-1:0]           cfg_word,
    input logic                      sel_ext,
    input logic [CTX_W-1:0]          ext_idx,
    input ctx_word_t                 act_ctx,
    input logic [NUM_DST*DATA_W-1:0] result_regs,
    input logic [FLAG_N-1:0]         flags
);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((flags ^ $past(flags)) & ~$past(act_ctx.fmask)) == '0));

    // R10
    reg0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ctx.dst == 1'b1) |=> $stable(result_regs[0 +: DATA_W]));

    // R10
    reg1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ctx.dst == 1'b0) |=> $stable(result_regs[DATA_W +: DATA_W]));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_ctx.fmask[FZ] |=>
            (flags[FZ] == (result_regs[$past(act_ctx.dst)*DATA_W +: DATA_W] == '0)));

    // R8
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_ctx.fmask[FS] |=>
            (flags[FS] == result_regs[$past(act_ctx.dst)*DATA_W + DATA_W - 1]));

    if (MULTI_CTX != 0) begin : g_multi_chk
        // R2
        ctx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_we |=> (!sel_ext || (ext_idx != $past(cfg_idx)) ||
                        (act_ctx == ctx_word_t'($past(cfg_word)))));
    end

endmodule

bind mcalu mcalu_chk #(
    .DATA_W    (DATA_W),
    .CTX_W     (CTX_W),
    .MULTI_CTX (MULTI_CTX)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_word    (cfg_word),
    .sel_ext     (sel_ext),
    .ext_idx     (ext_idx),
    .act_ctx     (act_ctx),
    .result_regs (result_regs),
    .flags       (flags)
);

// File: tb/mcalu_bench.sv
module mcalu_bench;

    localparam int  W  = 32;
    localparam time TP = 8ns;

    typedef struct packed {
        logic        sel;
        logic [1:0]  eidx;
        logic [31:0] a;
        logic [31:0] b;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 32'h0000_0005, 32'h0000_0003},
        '{1'b1, 2'd1, 32'h0000_0000, 32'h0000_0009},
        '{1'b1, 2'd2, 32'hF0F0_0000, 32'h0000_0000},
        '{1'b1, 2'd3, 32'h0001_0000, 32'h0001_0000},
        '{1'b0, 2'd0, 32'h0000_0011, 32'h0000_0022},
        '{1'b0, 2'd0, 32'h8000_0000, 32'h8000_0000},
        '{1'b0, 2'd0, 32'h1234_5678, 32'h0000_0001},
        '{1'b0, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001},
        '{1'b0, 2'd0, 32'h0000_0003, 32'h0000_0007},
        '{1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_idx = '0;
    logic [12:0]   cfg_word = '0;
    logic          sel_ext = 1'b1;
    logic [1:0]    ext_idx = '0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [2*W-1:0] res_m, res_s;
    logic [3:0]    flg_m, flg_s;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [12:0] m_ctx [4];
    logic [31:0] m_reg [2][2];
    logic [3:0]  m_flg [2];

    always #(TP/2) clk = ~clk;

    mcalu #(.DATA_W(W), .NUM_CTX(4), .MULTI_CTX(1)) u_mcalu (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_word(cfg_word), .sel_ext(sel_ext), .ext_idx(ext_idx),
        .op_a(op_a), .op_b(op_b), .result_regs(res_m), .flags(flg_m)
    );

    mcalu #(.DATA_W(W), .NUM_CTX(4), .MULTI_CTX(0)) u_mcalu_single (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_word(cfg_word), .sel_ext(sel_ext), .ext_idx(ext_idx),
        .op_a(op_a), .op_b(op_b), .result_regs(res_s), .flags(flg_s)
    );

    function automatic logic [12:0] mk(input logic [3:0] opc, input logic [1:0] sa,
                                       input logic [1:0] sb, input logic d,
                                       input logic [3:0] m);
        return {opc, sa, sb, d, m};
    endfunction

    // reference result {V,S,C,Z, result} built from the requirement text
    function automatic logic [35:0] ref_op(input logic [3:0] opc, input logic [31:0] a,
                                           input logic [31:0] b);
        logic [31:0] r;
        logic c, v;
        logic [32:0] w;
        longint sx;
        logic [63:0] p;
        int s;
        s = int'(b[4:0]);
        c = 1'b0;
        v = 1'b0;
        case (opc)
            4'd1: begin
                w = {1'b0, a} + {1'b0, b};
                r = w[31:0];
                c = w[32];
                sx = longint'($signed(a)) + longint'($signed(b));
                v = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
            end
            4'd2: begin
                r = a - b;
                c = (a < b);
                sx = longint'($signed(a)) - longint'($signed(b));
                v = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
            end
            4'd3: r = a & b;
            4'd4: r = a | b;
            4'd5: r = a ^ b;
            4'd6: begin
                r = a << s;
                c = (s == 0) ? 1'b0 : a[32-s];
            end
            4'd7: begin
                r = $signed(a) >>> s;
                c = (s == 0) ? 1'b0 : a[s-1];
            end
            4'd8: begin
                p = {32'd0, a} * {32'd0, b};
                r = p[31:0];
                v = (p[63:32] != 32'd0);
            end
            default: r = a;
        endcase
        return {v, r[31], c, (r == 32'd0), r};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_ctx[i] = '0;
        for (int v = 0; v < 2; v++) begin
            m_reg[v][0] = '0;
            m_reg[v][1] = '0;
            m_flg[v]    = '0;
        end
    endtask

    task automatic model_step();
        for (int v = 0; v < 2; v++) begin
            logic [1:0]  idx;
            logic [12:0] cw;
            logic [31:0] xa, xb;
            logic [35:0] o;
            idx = (v == 1) ? 2'd0 : (sel_ext ? ext_idx : m_flg[0][1:0]);
            cw  = m_ctx[idx];
            case (cw[8:7])
                2'd0: xa = op_a;
                2'd1: xa = op_b;
                2'd2: xa = m_reg[v][0];
                default: xa = m_reg[v][1];
            endcase
            case (cw[6:5])
                2'd0: xb = op_a;
                2'd1: xb = op_b;
                2'd2: xb = m_reg[v][0];
                default: xb = m_reg[v][1];
            endcase
            o = ref_op(cw[12:9], xa, xb);
            m_reg[v][cw[4]] = o[31:0];
            m_flg[v] = (o[35:32] & cw[3:0]) | (m_flg[v] & ~cw[3:0]);
        end
        if (cfg_we) m_ctx[cfg_idx] = cfg_word;
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (res_m !== {m_reg[0][1], m_reg[0][0]} || flg_m !== m_flg[0]) begin
            n_bad++;
            $display("FAIL %s: regs=%h flags=%b expected regs=%h flags=%b",
                     tag, res_m, flg_m, {m_reg[0][1], m_reg[0][0]}, m_flg[0]);
        end
        n_chk++;
        if (res_s !== {m_reg[1][1], m_reg[1][0]} || flg_s !== m_flg[1]) begin
            n_bad++;
            $display("FAIL R11 (%s): regs=%h flags=%b expected regs=%h flags=%b",
                     tag, res_s, flg_s, {m_reg[1][1], m_reg[1][0]}, m_flg[1]);
        end
    endtask

    // called at a falling edge: drive, advance model, check at next falling edge
    task automatic step(input logic sel, input logic [1:0] eidx, input logic [31:0] a,
                        input logic [31:0] b, input logic we, input logic [1:0] widx,
                        input logic [12:0] wword, input string tag);
        sel_ext  = sel;
        ext_idx  = eidx;
        op_a     = a;
        op_b     = b;
        cfg_we   = we;
        cfg_idx  = widx;
        cfg_word = wword;
        model_step();
        @(negedge clk);
        cfg_we = 1'b0;
        compare(tag);
    endtask

    task automatic run_op(input logic [3:0] opc, input logic [31:0] a, input logic [31:0] b,
                          input string tag);
        step(1'b1, 2'd0, 32'd0, 32'd0, 1'b1, 2'd3, mk(opc, 2'd0, 2'd1, 1'b0, 4'hF), tag);
        step(1'b1, 2'd3, a, b, 1'b0, 2'd0, 13'd0, tag);
    endtask

    initial begin
        #(TP * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        // R1: cleared context 0 passes op_a into register 0, flags untouched
        step(1'b1, 2'd2, 32'h0000_1234, 32'hFFFF_FFFF, 1'b0, 2'd0, 13'd0, "R1 cleared ctx");

        // load contexts while running (R2)
        step(1'b1, 2'd0, 32'd0, 32'd0, 1'b1, 2'd0, mk(4'd1, 2'd0, 2'd1, 1'b0, 4'hF), "R2 load0");
        step(1'b1, 2'd0, 32'd1, 32'd2, 1'b1, 2'd1, mk(4'd2, 2'd2, 2'd1, 1'b1, 4'hF), "R2 load1");
        step(1'b1, 2'd2, 32'd4, 32'd4, 1'b1, 2'd2, mk(4'd5, 2'd0, 2'd3, 1'b0, 4'b0101), "R2 old word used");
        step(1'b1, 2'd2, 32'h55, 32'd0, 1'b1, 2'd3, mk(4'd8, 2'd0, 2'd1, 1'b1, 4'hF), "R2 new word used");

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].sel, VECS[i].eidx, VECS[i].a, VECS[i].b, 1'b0, 2'd0, 13'd0,
                 VECS[i].sel ? "R3 ext index" : "R4 flag index");
        end

        run_op(4'd1, 32'h7FFF_FFFF, 32'h0000_0001, "R5 add overflow");
        run_op(4'd1, 32'hFFFF_FFFF, 32'h0000_0001, "R5 add carry zero");
        run_op(4'd2, 32'h0000_0000, 32'h0000_0001, "R5 sub borrow");
        run_op(4'd2, 32'h8000_0000, 32'h0000_0001, "R5 sub overflow");
        run_op(4'd8, 32'h0001_0000, 32'h0001_0000, "R5 mul high word");
        run_op(4'd8, 32'h0000_1234, 32'h0000_0010, "R5 mul fits");
        run_op(4'd3, 32'hF0F0_F0F0, 32'h0FF0_0FF0, "R6 and");
        run_op(4'd4, 32'hF000_0000, 32'h0000_000F, "R6 or");
        run_op(4'd5, 32'hA5A5_A5A5, 32'hA5A5_A5A5, "R6 xor zero");
        run_op(4'd0, 32'h8765_4321, 32'h0000_0000, "R6 pass");
        run_op(4'd15, 32'h0BAD_F00D, 32'h1111_1111, "R6 unassigned code");
        run_op(4'd6, 32'h8000_0001, 32'h0000_0001, "R7 shl carry");
        run_op(4'd6, 32'h8000_0001, 32'h0000_0020, "R7 shl zero amount");
        run_op(4'd6, 32'h0000_0003, 32'h0000_001F, "R7 shl by 31");
        run_op(4'd7, 32'h8000_0000, 32'h0000_001F, "R7 sra by 31");
        run_op(4'd7, 32'h0000_0003, 32'h0000_0001, "R7 sra carry");
        run_op(4'd1, 32'h0000_0000, 32'h0000_0000, "R8 zero set");
        run_op(4'd2, 32'h0000_0001, 32'h0000_0002, "R8 sign set");

        // R9: only zero may update; sign/carry from previous result must stay
        step(1'b1, 2'd0, 32'd0, 32'd0, 1'b1, 2'd3, mk(4'd2, 2'd0, 2'd1, 1'b0, 4'b0001), "R9 load");
        step(1'b1, 2'd3, 32'd5, 32'd5, 1'b0, 2'd0, 13'd0, "R9 mask zero only");
        step(1'b1, 2'd3, 32'd1, 32'd9, 1'b0, 2'd0, 13'd0, "R9 masked sign held");

        // R10: register feedback into register 1
        step(1'b1, 2'd0, 32'd0, 32'd0, 1'b1, 2'd3, mk(4'd1, 2'd2, 2'd3, 1'b1, 4'hF), "R10 load");
        step(1'b1, 2'd3, 32'd0, 32'd0, 1'b0, 2'd0, 13'd0, "R10 r0+r1 into r1");
        step(1'b1, 2'd3, 32'd0, 32'd0, 1'b0, 2'd0, 13'd0, "R10 accumulate");

        // R11: flags steer multi unit to other contexts; single stays on ctx 0
        step(1'b1, 2'd0, 32'd0, 32'd0, 1'b1, 2'd0, mk(4'd2, 2'd0, 2'd1, 1'b0, 4'hF), "R11 load");
        step(1'b0, 2'd0, 32'd3, 32'd7, 1'b0, 2'd0, 13'd0, "R11 flag branch");
        step(1'b0, 2'd0, 32'd3, 32'd3, 1'b0, 2'd0, 13'd0, "R11 flag branch 2");
        step(1'b1, 2'd1, 32'd8, 32'd2, 1'b0, 2'd0, 13'd0, "R11 ext index ignored");

        // R1: reset in mid-run
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        compare("R1 mid-run reset");
        rst_n = 1'b1;
        step(1'b1, 2'd1, 32'h0000_00AA, 32'd1, 1'b0, 2'd0, 13'd0, "R1 ctx cleared");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule